// File: doc/BRIEF.md
# DRAM Self-Refresh Suspend Sequencer

This block is a hardware state machine that walks a memory system through a full suspend and resume. It takes the job away from a software routine that would otherwise have to run from on-chip memory while the external DRAM is unreachable. A single start pulse launches the sequence. The sequencer first waits for an idle window on the DRAM controller. It then parks the DRAM in self-refresh, drops the clock mode from run to direct-run, gates the DRAM clock and powers the PLL down. After that it raises a stop request and waits for a wake event.

On wake, the sequencer rebuilds the clock tree in the reverse order. It writes the PLL configuration back and waits for lock. Only then does it return to run mode and restore the DRAM clock, and it then commits the self-refresh exit. A one-cycle done pulse marks the end of resume.

Every wait on an external status, except the wait for wake, is bounded by a programmable cycle limit. A wait that is never satisfied parks the sequencer in an error state instead of leaving it hung.

Top module: `srf_suspend_seq`

## Requirements
- R1: After reset the sequencer is idle: `sr_req_o`, `sr_upd_o`, `stop_req_o`, `pll_wr_o`, `busy_o`, `done_o` and `err_o` are 0, while `run_sel_o` and `dram_clk_en_o` are 1.
- R2: After a start pulse, `sr_req_o` rises only after `dram_busy_i` has first been sampled high and then sampled low.
- R3: Self-refresh entry sets `sr_req_o` one cycle before a single-cycle `sr_upd_o` pulse. The sequencer then waits for `dram_sr_ack_i` to go high.
- R4: Once the acknowledge arrives, the sequencer acts on four consecutive cycles, in this order: `run_sel_o` falls (0 = direct-run), `dram_clk_en_o` falls, a PLL write is issued, and `stop_req_o` rises.
- R5: `stop_req_o` stays high until `wake_i` is sampled high. This wait has no time limit.
- R6: After wake, `stop_req_o` falls. On the next cycle the saved PLL word is written back, and run mode is not re-entered until `pll_lock_i` has been sampled high.
- R7: After lock, `run_sel_o` rises and `sr_req_o` falls in the same cycle, and `dram_clk_en_o` rises one cycle later. A single `sr_upd_o` pulse follows. Then, after `dram_sr_ack_i` has been sampled low, `done_o` pulses for exactly one cycle.
- R8: In any timed wait (busy high, busy low, self-refresh acknowledge, lock, self-refresh exit), the sequencer moves to the error state on the `timeout_i`+1-th cycle without the awaited condition. In the error state `err_o` is 1, `busy_o` is 0 and all control outputs keep the values they had.
- R9: A start pulse while `busy_o` is high has no effect on the sequence. A start pulse in the error state clears `err_o` and restarts from the busy-high wait.
- R10: The PLL word is captured from `pll_cfg_i` at the power-down step. It is written out with bit `PWR_BIT` cleared (power-up is active high by default), and exactly the captured word is written back on wake, whatever `pll_cfg_i` does meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a suspend/resume run |
| timeout_i | input | TMO_W | Cycle limit for each timed wait |
| dram_busy_i | input | 1 | DRAM controller busy status |
| dram_sr_ack_i | input | 1 | DRAM controller reports self-refresh active |
| wake_i | input | 1 | Wake event while stopped |
| pll_lock_i | input | 1 | PLL lock status |
| pll_cfg_i | input | CFG_W | Current PLL configuration word |
| sr_req_o | output | 1 | Self-refresh request level |
| sr_upd_o | output | 1 | Update strobe committing the request level |
| run_sel_o | output | 1 | 1 = run mode, 0 = direct-run mode |
| stop_req_o | output | 1 | Stop mode request |
| dram_clk_en_o | output | 1 | DRAM clock enable |
| pll_wr_o | output | 1 | PLL configuration write strobe |
| pll_cfg_o | output | CFG_W | PLL configuration word to write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at end of resume |
| err_o | output | 1 | Sequencer stopped on a timeout |

## Verification
The assertions assume that every status input is synchronous to `clk`. They also assume that the DRAM controller and the PLL change their status only in reply to the sequencer's own strobes: the acknowledge follows an update pulse, and lock follows a power-up write. The stimulus keeps to this by driving the acknowledge and lock from small bench models that react to `sr_upd_o` and `pll_wr_o` with fixed latencies. Only the busy and wake lines are driven directly. The lock-timeout scenario is the one place where a model is told to withhold its answer.

// File: rtl/srf_seq_pkg.sv
package srf_seq_pkg;

   typedef enum logic [4:0] {
      S_IDLE, S_BUSY_HI, S_BUSY_LO, S_SR_SET, S_SR_UPD, S_SR_ACK,
      S_DIRECT, S_CLK_OFF, S_PLL_OFF, S_STOP, S_WAKE, S_PLL_ON,
      S_LOCK, S_RUN, S_CLK_ON, S_EXIT_UPD, S_SR_EXIT, S_ERR
   } seq_state_e;

   typedef struct packed {
      logic sr_req;
      logic upd;
      logic run_sel;
      logic stop;
      logic clk_en;
      logic pll_wr;
   } seq_ctl_t;

   // Waits that carry a cycle limit (the stop wait is open-ended)
   function automatic logic is_timed(seq_state_e s);
      return s inside {S_BUSY_HI, S_BUSY_LO, S_SR_ACK, S_LOCK, S_SR_EXIT};
   endfunction

   // Control levels owned by each state
   function automatic seq_ctl_t ctl_of(seq_state_e s);
      seq_ctl_t c;
      c.sr_req  = s inside {S_SR_SET, S_SR_UPD, S_SR_ACK, S_DIRECT, S_CLK_OFF,
                            S_PLL_OFF, S_STOP, S_WAKE, S_PLL_ON, S_LOCK};
      c.upd     = s inside {S_SR_UPD, S_EXIT_UPD};
      c.run_sel = !(s inside {S_DIRECT, S_CLK_OFF, S_PLL_OFF, S_STOP,
                              S_WAKE, S_PLL_ON, S_LOCK});
      c.stop    = (s == S_STOP);
      c.clk_en  = !(s inside {S_CLK_OFF, S_PLL_OFF, S_STOP, S_WAKE,
                              S_PLL_ON, S_LOCK, S_RUN});
      c.pll_wr  = s inside {S_PLL_OFF, S_PLL_ON};
      return c;
   endfunction

endpackage

// File: rtl/srf_seq_timer.sv
module srf_seq_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             waiting_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             expired_o
);
   logic [TMO_W-1:0] cnt_q;

   assign expired_o = waiting_i && (cnt_q == limit_i);

   always_ff @(posedge clk) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (clr_i)                   cnt_q <= '0;
      else if (waiting_i && !expired_o) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/srf_seq_fsm.sv
module srf_seq_fsm
   import srf_seq_pkg::*;
(
   input  seq_state_e state_i,
   input  logic       start_i,
   input  logic       busy_i,
   input  logic       ack_i,
   input  logic       wake_i,
   input  logic       lock_i,
   input  logic       expired_i,
   output seq_state_e state_o
);
   always_comb begin
      state_o = state_i;
      unique case (state_i)
         S_IDLE:     if (start_i) state_o = S_BUSY_HI;
         S_ERR:      if (start_i) state_o = S_BUSY_HI;
         S_BUSY_HI:  if (busy_i) state_o = S_BUSY_LO;
                     else if (expired_i) state_o = S_ERR;
         S_BUSY_LO:  if (!busy_i) state_o = S_SR_SET;
                     else if (expired_i) state_o = S_ERR;
         S_SR_SET:   state_o = S_SR_UPD;
         S_SR_UPD:   state_o = S_SR_ACK;
         S_SR_ACK:   if (ack_i) state_o = S_DIRECT;
                     else if (expired_i) state_o = S_ERR;
         S_DIRECT:   state_o = S_CLK_OFF;
         S_CLK_OFF:  state_o = S_PLL_OFF;
         S_PLL_OFF:  state_o = S_STOP;
         S_STOP:     if (wake_i) state_o = S_WAKE;
         S_WAKE:     state_o = S_PLL_ON;
         S_PLL_ON:   state_o = S_LOCK;
         S_LOCK:     if (lock_i) state_o = S_RUN;
                     else if (expired_i) state_o = S_ERR;
         S_RUN:      state_o = S_CLK_ON;
         S_CLK_ON:   state_o = S_EXIT_UPD;
         S_EXIT_UPD: state_o = S_SR_EXIT;
         S_SR_EXIT:  if (!ack_i) state_o = S_IDLE;
                     else if (expired_i) state_o = S_ERR;
         default:    state_o = S_IDLE;
      endcase
   end
endmodule

// File: rtl/srf_seq_pllsave.sv
module srf_seq_pllsave #(
   parameter int CFG_W    = 8,
   parameter int PWR_BIT  = 7,
   parameter bit PWR_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_i,
   input  logic             rest_i,
   input  logic [CFG_W-1:0] cfg_i,
   output logic [CFG_W-1:0] cfg_o
);
   localparam logic [CFG_W-1:0] PWR_MASK = CFG_W'(1) << PWR_BIT;

   logic [CFG_W-1:0] saved_q;
   logic [CFG_W-1:0] out_q;
   logic [CFG_W-1:0] down_w;

   generate
      if (PWR_HIGH) begin : g_pwr_high
         assign down_w = cfg_i & ~PWR_MASK;
      end else begin : g_pwr_low
         assign down_w = cfg_i | PWR_MASK;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         saved_q <= '0;
         out_q   <= '0;
      end else if (cap_i) begin
         saved_q <= cfg_i;
         out_q   <= down_w;
      end else if (rest_i) begin
         out_q   <= saved_q;
      end
   end

   assign cfg_o = out_q;
endmodule

// File: rtl/srf_suspend_seq.sv
module srf_suspend_seq
   import srf_seq_pkg::*;
#(
   parameter int TMO_W    = 16,
   parameter int CFG_W    = 8,
   parameter int PWR_BIT  = 7,
   parameter bit PWR_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [TMO_W-1:0] timeout_i,
   input  logic             dram_busy_i,
   input  logic             dram_sr_ack_i,
   input  logic             wake_i,
   input  logic             pll_lock_i,
   input  logic [CFG_W-1:0] pll_cfg_i,
   output logic             sr_req_o,
   output logic             sr_upd_o,
   output logic             run_sel_o,
   output logic             stop_req_o,
   output logic             dram_clk_en_o,
   output logic             pll_wr_o,
   output logic [CFG_W-1:0] pll_cfg_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);
   generate
      if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo
         $error("TMO_W must lie in 1..32");
      end
      if (PWR_BIT < 0 || PWR_BIT >= CFG_W) begin : g_bad_pwr
         $error("PWR_BIT must index inside the PLL word");
      end
   endgenerate

   seq_state_e state_q, state_d;
   seq_ctl_t   ctl_q;
   logic       err_q, done_q, expired;

   srf_seq_fsm u_fsm (
      .state_i   (state_q),
      .start_i   (start_i),
      .busy_i    (dram_busy_i),
      .ack_i     (dram_sr_ack_i),
      .wake_i    (wake_i),
      .lock_i    (pll_lock_i),
      .expired_i (expired),
      .state_o   (state_d)
   );

   srf_seq_timer #(.TMO_W(TMO_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (state_d != state_q),
      .waiting_i (is_timed(state_q)),
      .limit_i   (timeout_i),
      .expired_o (expired)
   );

   srf_seq_pllsave #(
      .CFG_W(CFG_W), .PWR_BIT(PWR_BIT), .PWR_HIGH(PWR_HIGH)
   ) u_pll (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (state_d == S_PLL_OFF && state_q != S_PLL_OFF),
      .rest_i (state_d == S_PLL_ON && state_q != S_PLL_ON),
      .cfg_i  (pll_cfg_i),
      .cfg_o  (pll_cfg_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         ctl_q   <= ctl_of(S_IDLE);
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_d != S_ERR) ctl_q <= ctl_of(state_d);
         err_q   <= (state_d == S_ERR);
         done_q  <= (state_q == S_SR_EXIT) && (state_d == S_IDLE);
      end
   end

   assign sr_req_o      = ctl_q.sr_req;
   assign sr_upd_o      = ctl_q.upd;
   assign run_sel_o     = ctl_q.run_sel;
   assign stop_req_o    = ctl_q.stop;
   assign dram_clk_en_o = ctl_q.clk_en;
   assign pll_wr_o      = ctl_q.pll_wr;
   assign busy_o        = (state_q != S_IDLE) && (state_q != S_ERR);
   assign done_o        = done_q;
   assign err_o         = err_q;
endmodule

// File: rtl/srf_suspend_seq_chk.sv
module srf_suspend_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic dram_busy_i,
   input logic dram_sr_ack_i,
   input logic pll_lock_i,
   input logic sr_req_o,
   input logic sr_upd_o,
   input logic run_sel_o,
   input logic stop_req_o,
   input logic dram_clk_en_o,
   input logic busy_o,
   input logic done_o,
   input logic err_o
);
   // R2
   req_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_req_o) |-> $past(!dram_busy_i));

   // R3
   upd_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_upd_o) |-> $stable(sr_req_o));

   // R3
   upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sr_upd_o |=> !sr_upd_o);

   // R4
   stop_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req_o |-> (!run_sel_o && !dram_clk_en_o && sr_req_o));

   // R6
   run_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_sel_o) |-> $past(pll_lock_i));

   // R7
   clk_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_clk_en_o) |-> (run_sel_o && $stable(run_sel_o) && !sr_req_o));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   done_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(!dram_sr_ack_i));

   // R8
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o);
endmodule

bind srf_suspend_seq srf_suspend_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .dram_busy_i   (dram_busy_i),
   .dram_sr_ack_i (dram_sr_ack_i),
   .pll_lock_i    (pll_lock_i),
   .sr_req_o      (sr_req_o),
   .sr_upd_o      (sr_upd_o),
   .run_sel_o     (run_sel_o),
   .stop_req_o    (stop_req_o),
   .dram_clk_en_o (dram_clk_en_o),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .err_o         (err_o)
);

// File: tb/srf_suspend_seq_bench.sv
module srf_suspend_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] timeout_i = 16'd20;
   logic        dram_busy_i = 1'b0;
   logic        dram_sr_ack_i;
   logic        wake_i = 1'b0;
   logic        pll_lock_i;
   logic [7:0]  pll_cfg_i = 8'hA5;
   logic        sr_req_o, sr_upd_o, run_sel_o, stop_req_o, dram_clk_en_o;
   logic        pll_wr_o, busy_o, done_o, err_o;
   logic [7:0]  pll_cfg_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   srf_suspend_seq u_srf_suspend_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .timeout_i(timeout_i),
      .dram_busy_i(dram_busy_i), .dram_sr_ack_i(dram_sr_ack_i),
      .wake_i(wake_i), .pll_lock_i(pll_lock_i), .pll_cfg_i(pll_cfg_i),
      .sr_req_o(sr_req_o), .sr_upd_o(sr_upd_o), .run_sel_o(run_sel_o),
      .stop_req_o(stop_req_o), .dram_clk_en_o(dram_clk_en_o),
      .pll_wr_o(pll_wr_o), .pll_cfg_o(pll_cfg_o), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // DRAM controller model: acknowledge follows the committed level 3 cycles later
   logic       a_tgt;
   logic [2:0] a_cnt;
   always @(posedge clk) begin
      if (!rst_n) begin
         dram_sr_ack_i <= 1'b0; a_cnt <= '0; a_tgt <= 1'b0;
      end else if (sr_upd_o) begin
         a_tgt <= sr_req_o; a_cnt <= 3'd3;
      end else if (a_cnt != 0) begin
         a_cnt <= a_cnt - 1'b1;
         if (a_cnt == 1) dram_sr_ack_i <= a_tgt;
      end
   end

   // PLL model: lock drops on power-down write, returns 4 cycles after power-up write
   logic       lock_en = 1'b1;
   logic [2:0] l_cnt;
   always @(posedge clk) begin
      if (!rst_n) begin
         pll_lock_i <= 1'b1; l_cnt <= '0;
      end else if (pll_wr_o) begin
         if (pll_cfg_o[7]) l_cnt <= 3'd4;
         else begin pll_lock_i <= 1'b0; l_cnt <= '0; end
      end else if (l_cnt != 0) begin
         l_cnt <= l_cnt - 1'b1;
         if (l_cnt == 1 && lock_en) pll_lock_i <= 1'b1;
      end
   end

   // Output-change monitor
   int   ev [64];
   int   ev_cyc [64];
   int   ev_n = 0;
   int   done_cnt = 0;
   int   ack_fall = 0, lock_rise = 0, busy_fall = 0;
   logic [7:0] pll_down_val, pll_up_val;
   logic p_req = 0, p_upd = 0, p_run = 1, p_clk = 1, p_stop = 0;
   logic p_ack = 0, p_lock = 1;

   task automatic push(input int code);
      if (ev_n < 64) begin ev[ev_n] = code; ev_cyc[ev_n] = cyc; ev_n++; end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (!p_req && sr_req_o) push(1);
         if (!p_upd && sr_upd_o) push(2);
         if (p_upd && !sr_upd_o) push(3);
         if (p_run && !run_sel_o) push(4);
         if (p_clk && !dram_clk_en_o) push(5);
         if (pll_wr_o && !pll_cfg_o[7]) begin push(6); pll_down_val = pll_cfg_o; end
         if (!p_stop && stop_req_o) push(7);
         if (p_stop && !stop_req_o) push(8);
         if (pll_wr_o && pll_cfg_o[7]) begin push(9); pll_up_val = pll_cfg_o; end
         if (!p_run && run_sel_o) push(10);
         if (p_req && !sr_req_o) push(11);
         if (!p_clk && dram_clk_en_o) push(12);
         if (done_o) begin push(13); done_cnt++; end
         if (p_ack && !dram_sr_ack_i) ack_fall = cyc;
         if (!p_lock && pll_lock_i) lock_rise = cyc;
      end
      p_req = sr_req_o; p_upd = sr_upd_o; p_run = run_sel_o; p_clk = dram_clk_en_o;
      p_stop = stop_req_o; p_ack = dram_sr_ack_i; p_lock = pll_lock_i;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input int i);
      if (i < 3) return "R3";
      if (i < 7) return "R4";
      if (i < 9) return "R6";
      return "R7";
   endfunction

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   // R1
   task automatic t_reset();
      @(negedge clk);
      chk(sr_req_o == 0 && sr_upd_o == 0 && stop_req_o == 0 && pll_wr_o == 0,
          "R1", "idle strobes", {sr_req_o, sr_upd_o, stop_req_o, pll_wr_o}, 0);
      chk(run_sel_o == 1 && dram_clk_en_o == 1, "R1", "run and clock",
          {run_sel_o, dram_clk_en_o}, 3);
      chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1", "status",
          {busy_o, done_o, err_o}, 0);
   endtask

   // Full suspend/resume; R2..R7, R9, R10
   task automatic t_cycle(input bit poke, input bit pulse);
      int n;
      int exp_ev [15] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 2, 3, 13};
      timeout_i = 16'd20; pll_cfg_i = 8'hA5; ev_n = 0; done_cnt = 0;
      if (pulse) pulse_start();
      dram_busy_i = 1'b0;
      repeat (2) @(negedge clk);
      dram_busy_i = 1'b1;
      repeat (4) @(negedge clk);
      dram_busy_i = 1'b0; busy_fall = cyc;
      n = 0;
      while (!stop_req_o && n < 200) begin @(negedge clk); n++; end
      if (poke) begin
         start_i = 1'b1; @(negedge clk); start_i = 1'b0;
         chk(busy_o == 1, "R9", "busy after ignored start", busy_o, 1);
      end
      pll_cfg_i = 8'h11;
      repeat (40) @(negedge clk);
      chk(stop_req_o == 1, "R5", "stop held without wake", stop_req_o, 1);
      chk(err_o == 0, "R5", "no timeout in stop wait", err_o, 0);
      wake_i = 1'b1; @(negedge clk); wake_i = 1'b0;
      n = 0;
      while (busy_o && n < 300) begin @(negedge clk); n++; end
      repeat (3) @(negedge clk);
      chk(ev_n == 15, poke ? "R9" : "R7", "event count", ev_n, 15);
      for (int i = 0; i < 15; i++)
         chk(ev[i] == exp_ev[i], req_of(i), $sformatf("event %0d", i), ev[i], exp_ev[i]);
      chk(ev_cyc[0] > busy_fall, "R2", "request after busy fell", ev_cyc[0], busy_fall + 1);
      chk(ev_cyc[1] == ev_cyc[0] + 1 && ev_cyc[2] == ev_cyc[1] + 1, "R3",
          "request then one-cycle update", ev_cyc[2] - ev_cyc[0], 2);
      for (int i = 4; i < 7; i++)
         chk(ev_cyc[i] == ev_cyc[i-1] + 1, "R4", "step spacing", ev_cyc[i] - ev_cyc[i-1], 1);
      chk(ev_cyc[8] == ev_cyc[7] + 1, "R6", "PLL write after stop drop",
          ev_cyc[8] - ev_cyc[7], 1);
      chk(ev_cyc[9] > lock_rise, "R6", "run after lock", ev_cyc[9], lock_rise + 1);
      chk(ev_cyc[9] == ev_cyc[10] && ev_cyc[11] == ev_cyc[9] + 1, "R7",
          "run, request clear, then clock", ev_cyc[11] - ev_cyc[9], 1);
      chk(ev_cyc[14] > ack_fall, "R7", "done after exit ack", ev_cyc[14], ack_fall + 1);
      chk(done_cnt == 1, "R7", "one done pulse", done_cnt, 1);
      chk(pll_down_val == 8'h25, "R10", "power-down word", pll_down_val, 8'h25);
      chk(pll_up_val == 8'hA5, "R10", "restored word", pll_up_val, 8'hA5);
      chk(busy_o == 0 && err_o == 0, "R7", "idle after resume", {busy_o, err_o}, 0);
   endtask

   // R8: busy never seen high
   task automatic t_busy_timeout();
      timeout_i = 16'd5; dram_busy_i = 1'b0;
      pulse_start();
      repeat (5) @(negedge clk);
      chk(err_o == 0, "R8", "no error before limit", err_o, 0);
      @(negedge clk);
      chk(err_o == 1, "R8", "error at limit+1", err_o, 1);
      chk(busy_o == 0, "R8", "not busy in error", busy_o, 0);
      chk(sr_req_o == 0 && run_sel_o == 1, "R8", "outputs held",
          {sr_req_o, run_sel_o}, 1);
   endtask

   // R9: restart from error
   task automatic t_restart();
      timeout_i = 16'd20;
      pulse_start();
      chk(err_o == 0, "R9", "error cleared by start", err_o, 0);
      chk(busy_o == 1, "R9", "restarted", busy_o, 1);
      t_cycle(1'b0, 1'b0);
   endtask

   // R8: lock never returns
   task automatic t_lock_timeout();
      int n;
      lock_en = 1'b0; timeout_i = 16'd20; dram_busy_i = 1'b0;
      pulse_start();
      dram_busy_i = 1'b1; repeat (3) @(negedge clk); dram_busy_i = 1'b0;
      n = 0;
      while (!stop_req_o && n < 200) begin @(negedge clk); n++; end
      wake_i = 1'b1; @(negedge clk); wake_i = 1'b0;
      n = 0;
      while (!err_o && n < 200) begin @(negedge clk); n++; end
      chk(err_o == 1, "R8", "lock timeout error", err_o, 1);
      chk(run_sel_o == 0 && dram_clk_en_o == 0 && sr_req_o == 1, "R8",
          "outputs held at lock wait", {run_sel_o, dram_clk_en_o, sr_req_o}, 1);
      chk(busy_o == 0, "R8", "not busy in error", busy_o, 0);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cycle(1'b0, 1'b1);
      t_cycle(1'b1, 1'b1);
      t_busy_timeout();
      t_restart();
      t_lock_timeout();
      report();
      $finish;
   end
endmodule